// File: doc/BRIEF.md
# Right-Hand Wall-Following Steering Controller

This block is the steering brain of a small maze-walking robot. The robot keeps a wall on its right-hand side. Two touch feelers report contact: one on the left and one on the right. Each reads 1 while it presses against a wall. From these two bits, a five-mode Moore state machine picks one of three actuator commands: take a step forward, veer slightly left, or veer slightly right. Because the commands are decoded from the registered mode alone, a change in the feelers shows up on the commands one clock later.

The modes are:

- **SEEK**: no wall is known, so the robot walks straight until something is felt.
- **HUG**: the right feeler is on the wall, and the robot edges left while stepping.
- **TRACK**: the robot has just lost right-side contact, and it edges right while stepping.
- **GAP**: the wall has a break, and the robot keeps edging right until the wall returns.
- **PIVOT**: a wall is ahead, and the robot turns left on the spot until both feelers are clear.

The feelers and the commands are single-level control pins and have no handshake. The current mode is also brought out on a status port, which lets an integrator or a test observe the path the machine takes.

Top module: `wf_steer_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next mode is SEEK (`mode_code` = 0), with only `cmd_fwd` asserted. Feeler inputs have no effect during reset.
- R2: The commands depend only on the mode. The `mode_code` values are SEEK=0, HUG=1, TRACK=2, GAP=3 and PIVOT=4. The command bits {fwd, veer_left, veer_right} are:
  - SEEK: 100
  - HUG: 110
  - TRACK: 101
  - GAP: 101
  - PIVOT: 010
- R3: In SEEK, the machine stays in SEEK when both feelers read 0. It moves to PIVOT when either feeler reads 1.
- R4: In HUG, the next mode depends on the feelers:
  - left=1 (any right): PIVOT.
  - left=0, right=1: stay in HUG.
  - left=0, right=0: TRACK.
- R5: In TRACK, right=1 leads to HUG and right=0 leads to GAP. The left feeler is ignored.
- R6: In GAP, right=1 leads to HUG and right=0 keeps GAP. The left feeler is ignored.
- R7: In PIVOT, the machine stays in PIVOT while either feeler reads 1. It moves to TRACK when both read 0.
- R8: Feelers are sampled at the rising edge. A feeler change made between edges leaves the commands unchanged until the next rising edge, and the new commands appear right after that edge.
- R9: `cmd_veer_left` and `cmd_veer_right` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_left | input | 1 | Left feeler, 1 = touching a wall |
| touch_right | input | 1 | Right feeler, 1 = touching a wall |
| cmd_fwd | output | 1 | Step forward |
| cmd_veer_left | output | 1 | Turn slightly left |
| cmd_veer_right | output | 1 | Turn slightly right |
| mode_code | output | 3 | Current mode (encoding in R2) |

## Verification
The bench builds the block with its default package values: a 3-bit mode code with five legal codes. At that width every legal mode can be reached from the feelers within a few cycles of reset. A vector walk therefore visits every mode and crosses each transition arc, including the arcs where the left feeler must be ignored. Directed tests then cover reset taking effect mid-walk and the one-edge delay between a feeler change and the command change.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SEEK  = 3'd0,
    MODE_HUG   = 3'd1,
    MODE_TRACK = 3'd2,
    MODE_GAP   = 3'd3,
    MODE_PIVOT = 3'd4
  } wf_mode_e;

  typedef struct packed {
    logic fwd;
    logic veer_l;
    logic veer_r;
  } wf_cmd_t;
endpackage

// File: rtl/wf_next_mode.sv
module wf_next_mode
  import wf_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              feel_l,
  input  logic              feel_r,
  output logic [MODE_W-1:0] nxt_mode
);
  logic any_touch;
  assign any_touch = feel_l | feel_r;

  always_comb begin
    case (cur_mode)
      MODE_SEEK:  nxt_mode = any_touch ? MODE_PIVOT : MODE_SEEK;
      MODE_HUG: begin
        if (feel_l)      nxt_mode = MODE_PIVOT;
        else if (feel_r) nxt_mode = MODE_HUG;
        else             nxt_mode = MODE_TRACK;
      end
      MODE_TRACK: nxt_mode = feel_r ? MODE_HUG : MODE_GAP;
      MODE_GAP:   nxt_mode = feel_r ? MODE_HUG : MODE_GAP;
      MODE_PIVOT: nxt_mode = any_touch ? MODE_PIVOT : MODE_TRACK;
      default:    nxt_mode = MODE_SEEK;
    endcase
  end
endmodule

// File: rtl/wf_cmd_decode.sv
module wf_cmd_decode
  import wf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output wf_cmd_t           cmd
);
  always_comb begin
    cmd = '0;
    case (mode)
      MODE_SEEK:  cmd.fwd = 1'b1;
      MODE_HUG:   begin cmd.fwd = 1'b1; cmd.veer_l = 1'b1; end
      MODE_TRACK,
      MODE_GAP:   begin cmd.fwd = 1'b1; cmd.veer_r = 1'b1; end
      MODE_PIVOT: cmd.veer_l = 1'b1;
      default:    cmd.fwd = 1'b1;
    endcase
  end
endmodule

// File: rtl/wf_mode_reg.sv
module wf_mode_reg
  import wf_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = MODE_SEEK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] d,
  output logic [MODE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_MODE;
    else     q <= d;
  end
endmodule

// File: rtl/wf_steer_ctrl.sv
module wf_steer_ctrl
  import wf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              touch_left,
  input  logic              touch_right,
  output logic              cmd_fwd,
  output logic              cmd_veer_left,
  output logic              cmd_veer_right,
  output logic [MODE_W-1:0] mode_code
);
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_d;
  wf_cmd_t           cmd;

  wf_next_mode u_next (
    .cur_mode (mode_q),
    .feel_l   (touch_left),
    .feel_r   (touch_right),
    .nxt_mode (mode_d)
  );

  wf_mode_reg #(.RESET_MODE(MODE_SEEK)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (mode_d),
    .q   (mode_q)
  );

  wf_cmd_decode u_dec (
    .mode (mode_q),
    .cmd  (cmd)
  );

  assign cmd_fwd        = cmd.fwd;
  assign cmd_veer_left  = cmd.veer_l;
  assign cmd_veer_right = cmd.veer_r;
  assign mode_code      = mode_q;
endmodule

// File: rtl/wf_steer_chk.sv
module wf_steer_chk
  import wf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              touch_left,
  input logic              touch_right,
  input logic              cmd_fwd,
  input logic              cmd_veer_left,
  input logic              cmd_veer_right,
  input logic [MODE_W-1:0] mode_code
);
  AST_RESET_TO_SEEK: assert property (@(posedge clk)
    rst |=> (mode_code == MODE_SEEK && cmd_fwd && !cmd_veer_left && !cmd_veer_right)); // R1

  AST_FWD_UNLESS_PIVOT: assert property (@(posedge clk) disable iff (rst)
    cmd_fwd == (mode_code != MODE_PIVOT)); // R2

  AST_SEEK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_SEEK && !touch_left && !touch_right) |=> mode_code == MODE_SEEK); // R3

  AST_SEEK_TO_PIVOT: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_SEEK && (touch_left || touch_right)) |=> mode_code == MODE_PIVOT); // R3

  AST_HUG_LEFT_PIVOT: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_HUG && touch_left) |=> mode_code == MODE_PIVOT); // R4

  AST_TRACK_RIGHT_HUG: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_TRACK && touch_right) |=> mode_code == MODE_HUG); // R5

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_GAP && !touch_right) |=> mode_code == MODE_GAP); // R6

  AST_PIVOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MODE_PIVOT && !touch_left && !touch_right) |=> mode_code == MODE_TRACK); // R7

  AST_VEER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(cmd_veer_left && cmd_veer_right)); // R9

  AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (rst)
    mode_code <= MODE_PIVOT); // R2
endmodule

bind wf_steer_ctrl wf_steer_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .touch_left     (touch_left),
  .touch_right    (touch_right),
  .cmd_fwd        (cmd_fwd),
  .cmd_veer_left  (cmd_veer_left),
  .cmd_veer_right (cmd_veer_right),
  .mode_code      (mode_code)
);

// File: tb/tb_wf_steer_ctrl.sv
module tb_wf_steer_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tl_in = 1'b0;
  logic       tr_in = 1'b0;
  logic       fwd, vl, vr;
  logic [2:0] mode;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wf_steer_ctrl dut (
    .clk(clk), .rst(rst), .touch_left(tl_in), .touch_right(tr_in),
    .cmd_fwd(fwd), .cmd_veer_left(vl), .cmd_veer_right(vr), .mode_code(mode)
  );

  // Entry: {left, right, expected next mode}; starts from SEEK after reset.
  localparam int NV = 18;
  localparam logic [4:0] VEC [NV] = '{
    {1'b0,1'b0,3'd0}, // R3 SEEK hold
    {1'b0,1'b1,3'd4}, // R3 SEEK -> PIVOT
    {1'b1,1'b0,3'd4}, // R7 hold
    {1'b1,1'b1,3'd4}, // R7 hold
    {1'b0,1'b0,3'd2}, // R7 -> TRACK
    {1'b1,1'b0,3'd3}, // R5 left ignored -> GAP
    {1'b1,1'b0,3'd3}, // R6 left ignored
    {1'b0,1'b0,3'd3}, // R6 hold
    {1'b0,1'b1,3'd1}, // R6 -> HUG
    {1'b0,1'b1,3'd1}, // R4 hold
    {1'b0,1'b0,3'd2}, // R4 -> TRACK
    {1'b1,1'b1,3'd1}, // R5 -> HUG
    {1'b1,1'b0,3'd4}, // R4 -> PIVOT
    {1'b0,1'b0,3'd2}, // R7
    {1'b0,1'b0,3'd3}, // R5
    {1'b1,1'b1,3'd1}, // R6
    {1'b1,1'b1,3'd4}, // R4
    {1'b0,1'b0,3'd2}  // R7
  };

  function automatic logic [2:0] exp_cmd(input logic [2:0] m);
    case (m)
      3'd0: return 3'b100;
      3'd1: return 3'b110;
      3'd2, 3'd3: return 3'b101;
      3'd4: return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string arc_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_mode(input string tag, input logic [2:0] exp_m);
    checks++;
    if (mode !== exp_m) begin
      errors++;
      $display("FAIL %s mode: actual %0d expected %0d", tag, mode, exp_m);
    end
  endtask

  task automatic check_cmd(input string tag, input logic [2:0] exp_c);
    checks++;
    if ({fwd, vl, vr} !== exp_c) begin
      errors++;
      $display("FAIL %s cmd: actual %b expected %b", tag, {fwd, vl, vr}, exp_c);
    end
  endtask

  task automatic check_excl();
    checks++;
    if (vl && vr) begin
      errors++;
      $display("FAIL R9 veer: actual %b%b expected not 11", vl, vr);
    end
  endtask

  task automatic step(input logic l, input logic r);
    tl_in = l;
    tr_in = r;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state, feelers active during reset are ignored
    tl_in = 1'b1; tr_in = 1'b1;
    @(negedge clk);
    check_mode("R1", 3'd0);
    check_cmd("R1", 3'b100);
    rst = 1'b0;

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] prev;
      prev = mode;
      step(VEC[i][4], VEC[i][3]);
      check_mode(arc_tag(prev), VEC[i][2:0]);
      check_cmd("R2", exp_cmd(VEC[i][2:0]));
      check_excl();
    end
    // ended in TRACK

    // R8: change feelers between edges; commands hold until the edge
    tl_in = 1'b0; tr_in = 1'b1;
    #1;
    check_cmd("R8 before edge", 3'b101);
    check_mode("R8 before edge", 3'd2);
    @(negedge clk);
    check_cmd("R8 after edge", 3'b110);
    check_mode("R8 after edge", 3'd1);

    // R1: reset mid-run from HUG
    rst = 1'b1;
    step(1'b0, 1'b1);
    check_mode("R1 mid-run", 3'd0);
    check_cmd("R1 mid-run", 3'b100);
    rst = 1'b0;

    // R3: left feeler alone also leaves SEEK
    step(1'b1, 1'b0);
    check_mode("R3 left only", 3'd4);
    check_cmd("R2 pivot", 3'b010);

    // R6: GAP with both feelers returns to HUG
    step(1'b0, 1'b0); // TRACK
    step(1'b0, 1'b0); // GAP
    check_mode("R5 gap entry", 3'd3);
    step(1'b1, 1'b1);
    check_mode("R6 both", 3'd1);
    check_excl();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule